// File: doc/BRIEF.md
# Single-Bit Error Threshold Counter

This block counts corrected single-bit memory errors and flags them only once a programmable number of them has been seen. Uncorrectable (multi-bit) errors are flagged on the first occurrence. A memory controller feeds it one pulse per transaction from its error-correction logic. Software picks a trigger count, can load the counter directly, and clears the sticky flags by writing ones. A large trigger value lets occasional soft errors be corrected without interrupting the processor. A multi-bit failure still raises the interrupt at once.

The counter is 8 bits wide by default and holds at its maximum value instead of wrapping. Each time a single-bit event is counted, the resulting count is compared with the trigger. On a match the single-bit flag is set, provided reporting is enabled.

Top module: `sbe_tally_irq`

## Requirements
- R1: After reset the count is 0, both flags are 0 and `irq_o` is 0.
- R2: Each cycle with `sbe_evt_i` high, and with no count write in that cycle, raises `count_o` by one. The new value is visible after the next rising clock edge.
- R3: With the default saturating build, the count stops at 255. Further single-bit events leave it at 255.
- R4: With `count_wr_i` high, `count_o` takes the value of `count_wdata_i` after the next edge. A single-bit event in the same cycle is dropped and cannot set the single-bit flag.
- R5: With `report_en_i` high, a counted single-bit event whose resulting count equals `trig_i` sets `sbe_flag_o` after the next edge. Counted events that give any other value leave the flag unchanged.
- R6: With `trig_i` equal to 0 the single-bit flag is never set, because a counted event always yields a count of at least 1.
- R7: With `report_en_i` high, `mbe_evt_i` sets `mbe_flag_o` after the next edge, whatever the count. With `report_en_i` low, neither event sets a flag.
- R8: Both flags are sticky. Writing 1 to `flag_clr_i` bit 0 clears the single-bit flag, and bit 1 clears the multi-bit flag, after the next edge. A set condition in the same cycle as the clear wins.
- R9: `irq_o` is high in the same cycle whenever `report_en_i` is high and either flag is set. It is low while `report_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sbe_evt_i | input | 1 | One-cycle pulse per corrected single-bit error |
| mbe_evt_i | input | 1 | One-cycle pulse per uncorrectable error |
| report_en_i | input | 1 | Enables flag setting and the interrupt |
| trig_i | input | 8 | Trigger count for single-bit reporting |
| count_wr_i | input | 1 | Loads the counter from `count_wdata_i` |
| count_wdata_i | input | 8 | Value loaded into the counter |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 single-bit, bit 1 multi-bit |
| count_o | output | 8 | Current error count |
| sbe_flag_o | output | 1 | Sticky single-bit report flag |
| mbe_flag_o | output | 1 | Sticky multi-bit report flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The count and both flags are registered. Each is due one rising edge after the cycle that carries the event, write or clear. The interrupt follows the flags and the enable input with no further delay. The bench changes inputs on the falling edge and holds them for exactly one rising edge. It then reads the outputs on the next falling edge, which is the first point where the registered results are due. For the mask check on `irq_o`, the enable is changed and then read within the same low half-cycle.

// File: rtl/sbe_tally_pkg.sv
`timescale 1ns/1ps
package sbe_tally_pkg;
   // Flag slots in the sticky report vector; bit position matches flag_clr_i.
   typedef enum int unsigned {
      FLAG_SBE = 0,
      FLAG_MBE = 1
   } flag_idx_e;

   localparam int unsigned NUM_FLAGS = 2;
   localparam int unsigned MIN_CNT_W = 2;
   localparam int unsigned MAX_CNT_W = 32;
endpackage

// File: rtl/sbe_count_sat.sv
`timescale 1ns/1ps
module sbe_count_sat #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic             counted_o,
   output logic [CNT_W-1:0] cnt_next_o,
   output logic [CNT_W-1:0] cnt_o
);
   import sbe_tally_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("sbe_count_sat: CNT_W out of supported range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             step_ok;

   // Variant choice: hold at the top value, or roll over to zero.
   generate
      if (SATURATE) begin : g_sat
         assign step_ok = inc_i && (cnt_q != CNT_MAX);
      end else begin : g_wrap
         assign step_ok = inc_i;
      end
   endgenerate

   // Value the counter reaches when the event is accepted (write not pending).
   assign cnt_next_o = step_ok ? cnt_q + CNT_ONE : cnt_q;
   assign counted_o  = inc_i && !wr_en_i;

   always_comb begin
      if (wr_en_i) cnt_d = wr_data_i;
      else         cnt_d = cnt_next_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R2: an accepted event below the ceiling adds exactly one
   a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !wr_en_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

   // R4: a load overrides any event in the same cycle
   a_r4_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (cnt_q == $past(wr_data_i)));

   // Without events or loads the count is steady
   a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !wr_en_i) |=> $stable(cnt_q));

   generate
      if (SATURATE) begin : g_sat_chk
         // R3: at the ceiling, events never wrap the count
         a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cnt_q == CNT_MAX && !wr_en_i) |=> (cnt_q == CNT_MAX));
      end
   endgenerate
endmodule

// File: rtl/sbe_flag_latch.sv
`timescale 1ns/1ps
module sbe_flag_latch #(
   parameter int unsigned N = sbe_tally_pkg::NUM_FLAGS
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("sbe_flag_latch: N must be at least 1");
      end
   endgenerate

   // One sticky bit per slot; a set in the same cycle beats the clear.
   for (genvar i = 0; i < N; i++) begin : g_slot
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        flag_q <= 1'b0;
         else if (set_i[i])  flag_q <= 1'b1;
         else if (clr_i[i])  flag_q <= 1'b0;
      end
      assign flag_o[i] = flag_q;

      // R8: a set flag stays until its clear bit is written
      a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flag_q && !clr_i[i]) |=> flag_q);

      // R8: set wins over a simultaneous clear
      a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[i] |=> flag_q);
   end
endmodule

// File: rtl/sbe_tally_irq.sv
`timescale 1ns/1ps
module sbe_tally_irq #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sbe_evt_i,
   input  logic             mbe_evt_i,
   input  logic             report_en_i,
   input  logic [CNT_W-1:0] trig_i,
   input  logic             count_wr_i,
   input  logic [CNT_W-1:0] count_wdata_i,
   input  logic [1:0]       flag_clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic             sbe_flag_o,
   output logic             mbe_flag_o,
   output logic             irq_o
);
   import sbe_tally_pkg::*;

   logic                 counted;
   logic [CNT_W-1:0]     cnt_next;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flags;

   sbe_count_sat #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) i_count (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (sbe_evt_i),
      .wr_en_i    (count_wr_i),
      .wr_data_i  (count_wdata_i),
      .counted_o  (counted),
      .cnt_next_o (cnt_next),
      .cnt_o      (count_o)
   );

   // Compare the post-increment value with the trigger.
   always_comb begin
      flag_set           = '0;
      flag_set[FLAG_SBE] = report_en_i && counted && (cnt_next == trig_i);
      flag_set[FLAG_MBE] = report_en_i && mbe_evt_i;
   end

   sbe_flag_latch #(
      .N (NUM_FLAGS)
   ) i_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set),
      .clr_i  (flag_clr_i),
      .flag_o (flags)
   );

   assign sbe_flag_o = flags[FLAG_SBE];
   assign mbe_flag_o = flags[FLAG_MBE];
   assign irq_o      = report_en_i && (|flags);

   // R7: an enabled multi-bit event always reports
   a_r7_mbe_reports: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mbe_evt_i && report_en_i) |=> mbe_flag_o);

   // R7: with reporting off, no flag rises
   a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!report_en_i && !sbe_flag_o) |=> !sbe_flag_o);

   // R5: single-bit flag rises only on a counted event that reaches the trigger
   a_r5_rise_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sbe_flag_o) |-> ($past(report_en_i) && $past(sbe_evt_i) && !$past(count_wr_i)
                             && count_o == $past(trig_i)));

   // R9: the request is masked while reporting is off
   a_r9_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !report_en_i |-> !irq_o);
endmodule

// File: tb/test_sbe_tally_irq.sv
`timescale 1ns/1ps
module test_sbe_tally_irq;
   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sbe = 1'b0, mbe = 1'b0, ren = 1'b0, wr = 1'b0;
   logic [W-1:0] trig = '0, wdata = '0;
   logic [1:0]   clr = '0;
   logic [W-1:0] cnt;
   logic         sflag, mflag, irq;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sbe_tally_irq #(.CNT_W(W)) i_sbe_tally_irq (
      .clk_i(clk), .rst_ni(rst_n), .sbe_evt_i(sbe), .mbe_evt_i(mbe),
      .report_en_i(ren), .trig_i(trig), .count_wr_i(wr), .count_wdata_i(wdata),
      .flag_clr_i(clr), .count_o(cnt), .sbe_flag_o(sflag), .mbe_flag_o(mflag),
      .irq_o(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Each helper drives on a falling edge, holds for one rising edge,
   // and returns on the following falling edge where results are due.
   task automatic sbe_pulses(int n);
      for (int i = 0; i < n; i++) begin
         sbe = 1'b1;
         @(negedge clk);
      end
      sbe = 1'b0;
   endtask

   task automatic load(logic [W-1:0] v);
      wr = 1'b1; wdata = v;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic clear(logic [1:0] b);
      clr = b;
      @(negedge clk);
      clr = 2'b00;
   endtask

   task automatic t_reset;
      check("R1 count", cnt, 0);
      check("R1 sbe flag", sflag, 0);
      check("R1 mbe flag", mflag, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic t_count;
      ren = 1'b1; trig = 8'd200;
      sbe_pulses(3);
      check("R2 count after 3", cnt, 3);
      check("R5 no flag below trigger", sflag, 0);
      @(negedge clk);
      check("R2 count holds when idle", cnt, 3);
   endtask

   task automatic t_report;
      load(8'd0); trig = 8'd5;
      sbe_pulses(4);
      check("R5 no flag at 4", sflag, 0);
      sbe_pulses(1);
      check("R5 flag at trigger", sflag, 1);
      check("R9 irq with flag", irq, 1);
      sbe_pulses(1);
      check("R2 count past trigger", cnt, 6);
   endtask

   task automatic t_sticky_clear;
      repeat (3) @(negedge clk);
      check("R8 sbe flag sticky", sflag, 1);
      clear(2'b10);
      check("R8 clear bit1 leaves sbe", sflag, 1);
      clear(2'b01);
      check("R8 clear bit0 clears sbe", sflag, 0);
      check("R9 irq low after clear", irq, 0);
   endtask

   task automatic t_mbe;
      load(8'd0); trig = 8'd200;
      mbe = 1'b1; @(negedge clk); mbe = 1'b0;
      check("R7 mbe flag at count 0", mflag, 1);
      check("R7 mbe leaves count", cnt, 0);
      check("R9 irq from mbe", irq, 1);
      clear(2'b01);
      check("R8 clear bit0 leaves mbe", mflag, 1);
      clear(2'b10);
      check("R8 clear bit1 clears mbe", mflag, 0);
   endtask

   task automatic t_disabled;
      ren = 1'b0; load(8'd1); trig = 8'd2;
      sbe_pulses(1);
      check("R7 no sbe flag when off", sflag, 0);
      mbe = 1'b1; @(negedge clk); mbe = 1'b0;
      check("R7 no mbe flag when off", mflag, 0);
      check("R2 counts while off", cnt, 2);
      ren = 1'b1;
   endtask

   task automatic t_write_priority;
      load(8'd9); trig = 8'd10;
      wr = 1'b1; wdata = 8'd9; sbe = 1'b1;
      @(negedge clk);
      wr = 1'b0; sbe = 1'b0;
      check("R4 write beats event", cnt, 9);
      check("R4 dropped event no flag", sflag, 0);
      load(8'd77);
      check("R4 load value", cnt, 77);
   endtask

   task automatic t_saturate;
      trig = 8'd100; load(8'd254);
      sbe_pulses(1);
      check("R3 reach 255", cnt, 255);
      sbe_pulses(2);
      check("R3 hold at 255", cnt, 255);
   endtask

   task automatic t_trig_zero;
      clear(2'b11);
      trig = 8'd0; load(8'd253);
      sbe_pulses(4);
      check("R6 trigger 0 never flags", sflag, 0);
      load(8'd0);
      sbe_pulses(1);
      check("R6 trigger 0 from zero", sflag, 0);
   endtask

   task automatic t_set_beats_clear;
      load(8'd6); trig = 8'd7;
      sbe = 1'b1; clr = 2'b01;
      @(negedge clk);
      sbe = 1'b0; clr = 2'b00;
      check("R8 sbe set beats clear", sflag, 1);
      mbe = 1'b1; clr = 2'b10;
      @(negedge clk);
      mbe = 1'b0; clr = 2'b00;
      check("R8 mbe set beats clear", mflag, 1);
   endtask

   task automatic t_irq_mask;
      ren = 1'b0; #1;
      check("R9 irq masked when off", irq, 0);
      check("R9 flags kept when off", sflag, 1);
      ren = 1'b1; #1;
      check("R9 irq back when on", irq, 1);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_report();
      t_sticky_clear();
      t_mbe();
      t_disabled();
      t_write_priority();
      t_saturate();
      t_trig_zero();
      t_set_beats_clear();
      t_irq_mask();
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule